// File: doc/BRIEF.md
# SD Sector Window Read Engine

This engine moves one sector of SD card read data from the 4-bit data lines into a byte-wide memory write port. Software first loads a 32-bit window word that holds a first offset, a limit offset and two mode flags. It then pulses a launch strobe together with a small command that carries a window-enable bit and a 2-bit destination select. Only bytes whose position in the sector lies in the half-open range [first, limit) reach memory. The engine drives the card clock as a one-cycle strobe and samples the data lines in every strobe cycle.

The two mode flags let the host chain sub-sector reads without another start-bit search. A read can start from a card already parked at the first offset, and it can stop at the limit offset and leave the card mid-sector. A read that does not stop early clocks through the rest of the sector and the trailing CRC and end bit, and discards them. CRC checking, command and response signalling, and card set-up belong to other blocks.

Top module: `sdpr_dma`

## Requirements
- R1: The window word takes effect from the launch after it is written. Bits [27:16] are the first offset and bits [11:0] the limit offset. Bit 31 selects resume mode and bit 15 selects early-stop mode. Each mode is decoded from that bit alone, so a field value of 8 turns it on and 0 turns it off.
- R2: Without resume mode, the engine strobes the card clock until it samples DAT0 low. That strobe consumes the start bit. Counting then begins at sector offset 0, and bytes before the first offset are dropped.
- R3: In resume mode there is no start-bit search. The first byte clocked in is treated as sector offset `first`.
- R4: Each byte is built from two nibble samples, upper nibble first. Only bytes at offsets in [first, min(limit, sector size)) are written. Within one transfer they go to addresses 0, 1, 2 and so on, and two writes never fall in back-to-back cycles.
- R5: Without early stop, the engine clocks to the end of the sector and then gives CRC_BITS+1 more strobes (CRC plus end bit) whose data is discarded.
- R6: In early-stop mode with a limit below the sector size, the engine ends with no further strobe once the byte at offset limit-1 has been taken. It also ends at once if it is already at or past the limit. A limit at or above the sector size is clamped to it and gives a full drain.
- R7: With window-enable (command bit 2) at 0, both offsets and both modes are ignored. The whole sector is read with a start-bit search and the full tail.
- R8: busy_o goes high in the cycle after an accepted launch and stays high until the transfer ends. The card clock strobe is active only while busy. done_o pulses for exactly one cycle, in the cycle busy_o falls.
- R9: A launch strobe while busy is ignored. The destination select (command bits 1:0) taken at the accepted launch drives mem_tgt_o for the whole transfer.
- R10: After reset, busy_o, done_o, sd_clk_o and mem_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the window word |
| cfg_word_i | input | 32 | Window word: modes and offsets |
| start_i | input | 1 | Launch strobe |
| start_cmd_i | input | 3 | Bit 2 window enable, bits 1:0 destination |
| sd_dat_i | input | 4 | Card data lines |
| sd_clk_o | output | 1 | Card clock strobe; data sampled in this cycle |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | 8 | Memory write data |
| mem_tgt_o | output | 2 | Destination select of the running transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with a 16-byte sector and a 5-bit address, keeping the default 16-bit CRC tail. This makes an exhaustive sweep practical. Every first and limit offset from 0 to 17 is run in all four mode combinations, so windows that are empty, inverted, full or clamped past the sector end are all covered. Each run checks the write count, the data and address sequence against a modelled card, and the exact number of clock strobes. Whole-sector runs with window-enable cleared, and launches made while busy, are checked as well.

// File: rtl/sdpr_pkg.sv
package sdpr_pkg;
  localparam int OFF_W = 12;
  localparam int CNT_W = OFF_W + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_DATA, ST_CRC} sdpr_state_e;

  typedef struct packed {
    logic             mid_start;
    logic             stop_mid;
    logic [CNT_W-1:0] first;
    logic [CNT_W-1:0] last;
  } sdpr_job_t;
endpackage

// File: rtl/sdpr_cfg.sv
module sdpr_cfg
  import sdpr_pkg::*;
#(
  parameter int SEC_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_word_i,
  input  logic        start_i,
  input  logic [2:0]  start_cmd_i,
  input  logic        busy_i,
  output logic        launch_o,
  output sdpr_job_t   job_o,
  output logic [1:0]  tgt_o
);
  localparam logic [CNT_W-1:0] SEC = CNT_W'(SEC_BYTES);

  logic [31:0]      word_q;
  sdpr_job_t        job_d, job_q;
  logic [1:0]       tgt_q;
  logic             win_en;
  logic [CNT_W-1:0] lim_raw;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       word_q <= '0;
    else if (cfg_we_i) word_q <= cfg_word_i;

  assign win_en   = start_cmd_i[2];
  assign launch_o = start_i && !busy_i;
  assign lim_raw  = {1'b0, word_q[11:0]};

  always_comb begin
    job_d.first     = win_en ? {1'b0, word_q[27:16]} : '0;
    job_d.last      = !win_en ? SEC : ((lim_raw > SEC) ? SEC : lim_raw);
    job_d.mid_start = win_en && word_q[31];
    job_d.stop_mid  = win_en && word_q[15] && (job_d.last < SEC);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      job_q <= '0;
      tgt_q <= '0;
    end else if (launch_o) begin
      job_q <= job_d;
      tgt_q <= start_cmd_i[1:0];
    end

  assign job_o = launch_o ? job_d : job_q;
  assign tgt_o = tgt_q;

  // R9
  ign_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> $stable(tgt_q) && $stable(job_q));
endmodule

// File: rtl/sdpr_fsm.sv
module sdpr_fsm
  import sdpr_pkg::*;
#(
  parameter int SEC_BYTES = 512,
  parameter int CRC_BITS  = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      launch_i,
  input  sdpr_job_t job_i,
  input  logic      dat0_i,
  output logic      sd_clk_o,
  output logic      busy_o,
  output logic      done_o,
  output logic      hi_fire_o,
  output logic      byte_fire_o
);
  localparam int TAIL = CRC_BITS + 1;
  localparam int TW   = $clog2(TAIL + 1);
  localparam logic [CNT_W-1:0] SEC = CNT_W'(SEC_BYTES);

  sdpr_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic [TW-1:0]    tail_q;
  logic             done_q;
  logic             clk_en, fin_sec, fin_mid, in_win;

  always_comb begin
    fin_sec = cnt_q >= SEC;
    fin_mid = job_i.stop_mid && (cnt_q >= job_i.last);
    clk_en  = 1'b0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch_i) state_d = job_i.mid_start ? ST_DATA : ST_SYNC;
      ST_SYNC: begin
        clk_en = 1'b1;
        if (!dat0_i) state_d = ST_DATA;   // this strobe eats the start bit
      end
      ST_DATA: begin
        if (fin_mid)      state_d = ST_IDLE;
        else if (fin_sec) state_d = ST_CRC;
        else              clk_en  = 1'b1;
      end
      ST_CRC: begin
        clk_en = 1'b1;
        if (tail_q == TW'(TAIL - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      if (state_q == ST_IDLE && launch_i) begin
        cnt_q  <= job_i.mid_start ? job_i.first : '0;
        half_q <= 1'b0;
        tail_q <= '0;
      end else if (state_q == ST_DATA && clk_en) begin
        half_q <= !half_q;
        if (half_q) cnt_q <= cnt_q + 1'b1;
      end else if (state_q == ST_CRC) begin
        tail_q <= tail_q + 1'b1;
      end
    end

  assign in_win      = (cnt_q >= job_i.first) && (cnt_q < job_i.last);
  assign hi_fire_o   = (state_q == ST_DATA) && clk_en && !half_q;
  assign byte_fire_o = (state_q == ST_DATA) && clk_en && half_q && in_win;
  assign sd_clk_o    = clk_en;
  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  // R8
  idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sd_clk_o);
  // R2
  sync_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_SYNC) |-> !$past(dat0_i));
endmodule

// File: rtl/sdpr_pack.sv
module sdpr_pack #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              hi_fire_i,
  input  logic              byte_fire_i,
  input  logic [3:0]        dat_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  logic [3:0]        hi_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hi_q       <= '0;
      ptr_q      <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= byte_fire_i;
      if (launch_i)  ptr_q <= '0;
      if (hi_fire_i) hi_q  <= dat_i;
      if (byte_fire_i) begin
        mem_data_o <= {hi_q, dat_i};
        mem_addr_o <= ptr_q;
        ptr_q      <= ptr_q + 1'b1;
      end
    end

  // R4
  wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/sdpr_dma.sv
module sdpr_dma
  import sdpr_pkg::*;
#(
  parameter int SEC_BYTES = 512,
  parameter int CRC_BITS  = 16,
  parameter int ADDR_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_word_i,
  input  logic              start_i,
  input  logic [2:0]        start_cmd_i,
  input  logic [3:0]        sd_dat_i,
  output logic              sd_clk_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [1:0]        mem_tgt_o,
  output logic              busy_o,
  output logic              done_o
);
  logic      launch, hi_fire, byte_fire;
  sdpr_job_t job;

  sdpr_cfg #(.SEC_BYTES(SEC_BYTES)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_word_i, .start_i, .start_cmd_i,
    .busy_i(busy_o), .launch_o(launch), .job_o(job), .tgt_o(mem_tgt_o)
  );

  sdpr_fsm #(.SEC_BYTES(SEC_BYTES), .CRC_BITS(CRC_BITS)) u_fsm (
    .clk_i, .rst_ni, .launch_i(launch), .job_i(job), .dat0_i(sd_dat_i[0]),
    .sd_clk_o, .busy_o, .done_o, .hi_fire_o(hi_fire), .byte_fire_o(byte_fire)
  );

  sdpr_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk_i, .rst_ni, .launch_i(launch), .hi_fire_i(hi_fire),
    .byte_fire_i(byte_fire), .dat_i(sd_dat_i),
    .mem_we_o, .mem_addr_o, .mem_data_o
  );
endmodule

// File: tb/sim_sdpr_dma.sv
module sim_sdpr_dma;
  localparam int S = 16;
  localparam int AW = 5;
  localparam int CRCB = 16;
  localparam int IDLE_N = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0, start = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic [2:0]    cmd = '0;
  logic [3:0]    sd_dat;
  logic          sd_clk, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic [1:0]    mem_tgt;

  int nchk = 0, nerr = 0;
  int seed = 0, card_idx = 0;
  int clk_cnt = 0, wcnt = 0, done_cnt = 0, data_bad = 0, tgt_bad = 0;
  int exp_first = 0, exp_tgt = 0;

  always #5 clk = !clk;

  sdpr_dma #(.SEC_BYTES(S), .CRC_BITS(CRCB), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_word_i(cfg_word),
    .start_i(start), .start_cmd_i(cmd), .sd_dat_i(sd_dat), .sd_clk_o(sd_clk),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_tgt_o(mem_tgt), .busy_o(busy), .done_o(done)
  );

  function automatic logic [7:0] pat(int b, int sd);
    return 8'(b * 29 + sd * 7 + 3);
  endfunction

  // card stream: idle high, start nibble 0, sector bytes, CRC nibbles, end nibble
  function automatic logic [3:0] nib(int idx, int sd);
    int d;
    logic [7:0] b;
    d = idx - IDLE_N - 1;
    if (idx < IDLE_N) return 4'hF;
    if (idx == IDLE_N) return 4'h0;
    if (d < 2 * S) begin
      b = pat(d / 2, sd);
      return (d % 2 == 0) ? b[7:4] : b[3:0];
    end
    if (d < 2 * S + CRCB) return 4'h6;
    return 4'hF;
  endfunction

  assign sd_dat = nib(card_idx, seed);

  always @(posedge clk) begin
    if (sd_clk) begin
      clk_cnt = clk_cnt + 1;
      card_idx <= card_idx + 1;
    end
    if (mem_we) begin
      if (mem_addr != AW'(wcnt) || mem_data != pat(exp_first + wcnt, seed)) data_bad = data_bad + 1;
      if (mem_tgt != 2'(exp_tgt)) tgt_bad = tgt_bad + 1;
      wcnt = wcnt + 1;
    end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int sm, input int ps, input int em, input int pe,
                     input bit win, input int tgt, input bit poke);
    int eps, epe, beg, pre, cons, nw, eclk, t;
    bit emid, estop;
    eps   = win ? ps : 0;
    epe   = win ? pe : S;
    if (epe > S) epe = S;
    emid  = win && (sm >= 8);
    estop = win && (em >= 8) && (epe < S);
    nw    = (eps < epe) ? epe - eps : 0;
    beg   = emid ? eps : 0;
    pre   = emid ? 0 : IDLE_N + 1;
    if (estop) begin
      cons = (beg < epe) ? epe - beg : 0;
      eclk = pre + 2 * cons;
    end else begin
      cons = (beg < S) ? S - beg : 0;
      eclk = pre + 2 * cons + CRCB + 1;
    end
    seed++;
    exp_first = eps; exp_tgt = tgt;
    wcnt = 0; clk_cnt = 0; done_cnt = 0; data_bad = 0; tgt_bad = 0;
    card_idx = emid ? IDLE_N + 1 + 2 * eps : 0;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_word = {4'(sm), 12'(ps), 4'(em), 12'(pe)};
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b1; cmd = {win, 2'(tgt)};
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R8 busy during transfer", int'(busy), 1);
      start = 1'b1; cmd = {1'b1, ~2'(tgt)};
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R8 transfer completes", t, 0);
    @(negedge clk);
    chk(wcnt == nw, "R4 write count", wcnt, nw);
    chk(data_bad == 0, "R4 R3 data/address sequence", data_bad, 0);
    chk(clk_cnt == eclk, win ? "R2 R5 R6 clock strobes" : "R7 whole sector strobes", clk_cnt, eclk);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    chk(busy == 1'b0, "R8 busy low after done", int'(busy), 0);
    chk(tgt_bad == 0, poke ? "R9 launch while busy ignored" : "R9 destination held", tgt_bad, 0);
  endtask

  initial begin
    #1_800_000;
    nerr++;
    $display("FAIL watchdog act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    chk(busy == 1'b0 && done == 1'b0 && sd_clk == 1'b0 && mem_we == 1'b0,
        "R10 reset state", int'({busy, done, sd_clk, mem_we}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: offsets and modes ignored without window enable
    for (int g = 0; g < 4; g++) run(8, 5 + g, 8, 2, 1'b0, g, 1'b0);
    // R9: late launch with a different destination
    for (int g = 0; g < 4; g++) run(0, 0, 0, 12, 1'b0, g, 1'b1);
    run(0, 2, 0, 14, 1'b1, 1, 1'b1);
    // R1 R2 R3 R5 R6: exhaustive window and mode sweep, incl. clamp above sector
    for (int m = 0; m < 4; m++)
      for (int a = 0; a <= S + 1; a++)
        for (int b = 0; b <= S + 1; b++)
          run((m & 1) * 8, a, (m >> 1) * 8, b, 1'b1, (a + b) % 4, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule